// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial bit stream. The clock is sixteen times the bit rate, so every bit lasts sixteen clock cycles. Each character is framed with one low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop interval.

The character path has two stages. A holding buffer takes the parallel input when the load strobe rises. A shift stage serialises one character. While the shift stage is busy, the buffer can already accept the next character. That character is handed over in the same cycle the current stop interval ends, so consecutive characters follow one another with no idle gap.

The word length, parity and stop selection are read from the control inputs at the moment a character moves from the buffer into the shift stage. Two flags are available to the user. One reports that the buffer can take a new character. The other reports that the shift stage has finished, including its stop bits.

Top module: `dbuf_uart_tx`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows txd high, buf_empty high and sr_empty high. Any character held or in flight is discarded.
- R2: A rising edge on tx_load is seen at the first clock edge where tx_load is high after being low. That edge stores tx_data and drives buf_empty low. When the shift stage is idle, buf_empty returns high one cycle later, as the character moves into the shift stage.
- R3: When a character enters an idle shift stage, txd goes low (start bit) in that same cycle. The start bit and every later data or parity bit each last exactly 16 clock cycles.
- R4: Data bits are sent least significant first. Their count is 5, 6, 7 or 8 for cfg_len = 0, 1, 2, 3. Input bits above the selected length have no effect on txd.
- R5: With cfg_par_off low, one parity bit follows the data. With cfg_par_even high, the parity bit makes the number of ones in data plus parity even. With cfg_par_even low, it makes that count odd.
- R6: With cfg_par_off high, no parity bit is sent, and the stop interval begins right after the last data bit.
- R7: The stop interval is high for 16 cycles when cfg_stop2 is low. When cfg_stop2 is high, it lasts 32 cycles, or 24 cycles when cfg_len selects 5 data bits.
- R8: sr_empty is low from the start bit until the last stop cycle. It goes high in the cycle after the stop interval ends, unless another character is pending.
- R9: A character loaded while the shift stage is busy waits in the buffer with buf_empty low. In the cycle right after the current stop interval, its start bit appears on txd, buf_empty goes high and sr_empty stays low.
- R10: Whenever the shift stage is idle, txd is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at sixteen times the bit rate |
| rst_n | input | 1 | Synchronous active-low master reset |
| tx_load | input | 1 | Load strobe; a rising edge stores tx_data in the buffer |
| tx_data | input | 8 | Character to send; bit 0 is sent first |
| cfg_len | input | 2 | Data bits: 0→5, 1→6, 2→7, 3→8 |
| cfg_par_off | input | 1 | High: no parity bit |
| cfg_par_even | input | 1 | High: even parity; low: odd parity |
| cfg_stop2 | input | 1 | Low: one stop bit; high: two (one and a half for 5-bit words) |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer can accept a character |
| sr_empty | output | 1 | Shift stage idle, last stop interval complete |

## Verification
Let A be the clock edge at which a character enters the shift stage. The start bit is visible right after edge A. The middle of frame bit k comes 16k+8 edges after A. The stop interval starts 16·n edges after A, where n is the number of start, data and parity bits. sr_empty rises a further 16, 24 or 32 edges later. From an idle stage, A is the edge after the one that samples the load strobe, and buf_empty is low in exactly that one cycle between the two. The bench counts these edges on the falling clock edge and compares txd and both flags there. It sweeps every word length, parity mode and stop setting with data whose upper bits are set, and it checks a back-to-back pair and a reset in mid-frame.

// File: rtl/dbuf_uart_tx_pkg.sv
// Shared types for the double-buffered serial transmitter.
package dbuf_uart_tx_pkg;

    // Frame sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BITS = 2'd1,
        ST_STOP = 2'd2
    } tx_state_e;

    // Character format, sampled when a character enters the shift stage.
    typedef struct packed {
        logic [1:0] len;       // 0..3 selects shortest..longest word
        logic       par_off;   // 1: no parity bit
        logic       par_even;  // 1: even parity, 0: odd
        logic       stop2;     // 1: long stop interval
    } tx_cfg_t;

endpackage

// File: rtl/dbuf_uart_tx_frame.sv
// Frame builder: purely combinational. Masks the character to the chosen
// length, computes parity and lays out the frame (bit 0 = start bit) with
// its bit count and stop interval length in clock cycles.
// Assumes DATA_W >= 4 so that the 2-bit length code spans DATA_W-3..DATA_W.
module dbuf_uart_tx_frame
    import dbuf_uart_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OVS     = 16,
    parameter int FRAME_W = DATA_W + 2,
    parameter int CNT_W   = $clog2(FRAME_W + 1),
    parameter int STOP_W  = $clog2(2 * OVS + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  tx_cfg_t            cfg,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits,
    output logic [STOP_W-1:0]  stop_ticks
);

    localparam int MIN_LEN = DATA_W - 3;

    int                nl;
    logic [DATA_W-1:0] masked;
    logic              par_bit;

    // Mask unused upper bits and compute the parity bit.
    always_comb begin
        nl = MIN_LEN + int'(cfg.len);
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = (i < nl) ? data[i] : 1'b0;
        end
        par_bit = cfg.par_even ? (^masked) : ~(^masked);
    end

    // Place start, data and parity bits; unused positions read as stop level.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nl) frame[i+1] = masked[i];
        end
        for (int j = 0; j < FRAME_W; j++) begin
            if (!cfg.par_off && j == nl + 1) frame[j] = par_bit;
        end
    end

    // Bit count before the stop interval, and stop interval length.
    always_comb begin
        nbits = CNT_W'(1 + nl + (cfg.par_off ? 0 : 1));
        if (!cfg.stop2)        stop_ticks = STOP_W'(OVS);
        else if (nl == MIN_LEN) stop_ticks = STOP_W'(OVS + OVS / 2);
        else                   stop_ticks = STOP_W'(2 * OVS);
    end

endmodule

// File: rtl/dbuf_uart_tx_hold.sv
// Holding buffer: detects the rising edge of the load strobe, stores the
// character and keeps a full flag until the shift stage takes it.
// Assumes the strobe is synchronous to clk. A load arriving in the same
// cycle as a take refills the buffer with the new character.
module dbuf_uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full
);

    logic load_q;
    logic load_rise;

    // Rising-edge detect of the load strobe.
    assign load_rise = load && !load_q;

    // Strobe history, buffer data and full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q    <= 1'b0;
            hold_full <= 1'b0;
            hold_data <= '0;
        end else begin
            load_q <= load;
            if (load_rise) begin
                hold_data <= din;
                hold_full <= 1'b1;
            end else if (take) begin
                hold_full <= 1'b0;
            end
        end
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load) |=> hold_full);

    p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !load_rise) |=> !hold_full);

endmodule

// File: rtl/dbuf_uart_tx_shift.sv
// Shift stage: serialises one frame, each bit OVS cycles long, then holds
// the line high for the stop interval. It takes the next buffered
// character in the last stop cycle, so characters run back to back.
// Assumes OVS is a power of two.
module dbuf_uart_tx_shift
    import dbuf_uart_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OVS     = 16,
    parameter int FRAME_W = DATA_W + 2,
    parameter int CNT_W   = $clog2(FRAME_W + 1),
    parameter int STOP_W  = $clog2(2 * OVS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_full,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   nbits,
    input  logic [STOP_W-1:0]  stop_ticks,
    output logic               take,
    output logic               txd,
    output logic               idle
);

    localparam int TICK_W = $clog2(OVS);

    tx_state_e          state_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [TICK_W-1:0]  tick_q;
    logic [CNT_W-1:0]   left_q;
    logic [STOP_W-1:0]  stopcnt_q;
    logic [STOP_W-1:0]  stoplen_q;
    logic               txd_q;
    logic               stop_last;

    // Hand-over condition: idle, or in the final cycle of the stop interval.
    always_comb begin
        stop_last = (state_q == ST_STOP) && (stopcnt_q == stoplen_q - STOP_W'(1));
        take      = hold_full && ((state_q == ST_IDLE) || stop_last);
    end

    // Frame sequencer: bit timing, shifting and stop interval count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            shreg_q   <= '1;
            tick_q    <= '0;
            left_q    <= '0;
            stopcnt_q <= '0;
            stoplen_q <= STOP_W'(OVS);
            txd_q     <= 1'b1;
        end else if (take) begin
            state_q   <= ST_BITS;
            txd_q     <= frame[0];
            shreg_q   <= frame >> 1;
            left_q    <= nbits - CNT_W'(1);
            tick_q    <= '0;
            stoplen_q <= stop_ticks;
        end else begin
            case (state_q)
                ST_BITS: begin
                    if (tick_q == TICK_W'(OVS - 1)) begin
                        tick_q <= '0;
                        if (left_q == '0) begin
                            state_q   <= ST_STOP;
                            stopcnt_q <= '0;
                            txd_q     <= 1'b1;
                        end else begin
                            txd_q   <= shreg_q[0];
                            shreg_q <= shreg_q >> 1;
                            left_q  <= left_q - CNT_W'(1);
                        end
                    end else begin
                        tick_q <= tick_q + TICK_W'(1);
                    end
                end
                ST_STOP: begin
                    if (stop_last) state_q   <= ST_IDLE;
                    else           stopcnt_q <= stopcnt_q + STOP_W'(1);
                end
                default: begin
                    txd_q <= 1'b1;
                end
            endcase
        end
    end

    assign txd  = txd_q;
    assign idle = (state_q == ST_IDLE);

    p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> txd_q);

    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> !txd_q);

    p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BITS && tick_q != '0) |-> $stable(txd_q));

    p_empty_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(idle) && $past(rst_n)) |-> $past(state_q == ST_STOP));

    p_back_to_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_last && hold_full) |=> (state_q == ST_BITS && !txd_q));

endmodule

// File: rtl/dbuf_uart_tx.sv
// Top of the double-buffered serial transmitter: holding buffer, frame
// builder and shift stage. The control inputs are read when a character
// moves from the buffer to the shift stage and must be steady then.
module dbuf_uart_tx
    import dbuf_uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_off,
    input  logic              cfg_par_even,
    input  logic              cfg_stop2,
    output logic              txd,
    output logic              buf_empty,
    output logic              sr_empty
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int STOP_W  = $clog2(2 * OVS + 1);

    tx_cfg_t            cfg;
    logic [DATA_W-1:0]  hold_data;
    logic               hold_full;
    logic               take;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;
    logic [STOP_W-1:0]  stop_ticks;
    logic               idle;

    // Gather the control inputs into one format word.
    always_comb begin
        cfg.len      = cfg_len;
        cfg.par_off  = cfg_par_off;
        cfg.par_even = cfg_par_even;
        cfg.stop2    = cfg_stop2;
    end

    dbuf_uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .din       (tx_data),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    dbuf_uart_tx_frame #(
        .DATA_W(DATA_W), .OVS(OVS), .FRAME_W(FRAME_W), .CNT_W(CNT_W), .STOP_W(STOP_W)
    ) u_frame (
        .data       (hold_data),
        .cfg        (cfg),
        .frame      (frame),
        .nbits      (nbits),
        .stop_ticks (stop_ticks)
    );

    dbuf_uart_tx_shift #(
        .DATA_W(DATA_W), .OVS(OVS), .FRAME_W(FRAME_W), .CNT_W(CNT_W), .STOP_W(STOP_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_full  (hold_full),
        .frame      (frame),
        .nbits      (nbits),
        .stop_ticks (stop_ticks),
        .take       (take),
        .txd        (txd),
        .idle       (idle)
    );

    assign buf_empty = !hold_full;
    assign sr_empty  = idle;

endmodule

// File: tb/dbuf_uart_tx_bench.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every format with two characters each, then
// checks back-to-back transfer and reset during a frame.
module dbuf_uart_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [1:0] cfg_len = 2'd0;
    logic       cfg_par_off = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       txd, buf_empty, sr_empty;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    dbuf_uart_tx u_dbuf_uart_tx (
        .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_data(tx_data),
        .cfg_len(cfg_len), .cfg_par_off(cfg_par_off), .cfg_par_even(cfg_par_even),
        .cfg_stop2(cfg_stop2), .txd(txd), .buf_empty(buf_empty), .sr_empty(sr_empty)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Checks one frame; called just after the edge where it entered the shift stage.
    task automatic decode(input logic [7:0] d, input int ln, input bit poff, input bit pev, input bit s2);
        int nl = 5 + ln;
        logic [7:0] m = d & 8'((1 << nl) - 1);
        logic p = pev ? ^m : ~^m;
        int st = s2 ? ((nl == 5) ? 24 : 32) : 16;
        check("R3", "start bit at entry", txd, 0);
        check("R8", "busy during frame", sr_empty, 0);
        step(8);
        check("R3", "start bit middle", txd, 0);
        for (int i = 0; i < nl; i++) begin
            step(16);
            check("R4", "data bit", txd, m[i]);
        end
        if (!poff) begin
            step(16);
            check("R5", "parity bit", txd, p);
        end
        step(8);
        if (poff) check("R6", "stop follows data", txd, 1);
        else      check("R7", "stop begins", txd, 1);
        step(st - 1);
        check("R7", "stop last cycle high", txd, 1);
        check("R8", "still busy in stop", sr_empty, 0);
        step(1);
        check("R8", "empty after stop", sr_empty, 1);
        check("R10", "idle line high", txd, 1);
    endtask

    task automatic set_cfg(input int ln, input bit poff, input bit pev, input bit s2);
        cfg_len = 2'(ln); cfg_par_off = poff; cfg_par_even = pev; cfg_stop2 = s2;
    endtask

    task automatic run_frame(input logic [7:0] d, input int ln, input bit poff, input bit pev, input bit s2);
        @(negedge clk);
        set_cfg(ln, poff, pev, s2);
        tx_data = d; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        check("R2", "buffer full after strobe", buf_empty, 0);
        @(negedge clk);
        check("R2", "buffer drained", buf_empty, 1);
        decode(d, ln, poff, pev, s2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        step(3);
        check("R1", "reset txd", txd, 1);
        check("R1", "reset buf_empty", buf_empty, 1);
        check("R1", "reset sr_empty", sr_empty, 1);
        rst_n = 1'b1;
        step(2);

        // Sweep all formats; data always has upper bits set.
        for (int ln = 0; ln < 4; ln++)
            for (int pm = 0; pm < 3; pm++)
                for (int s2 = 0; s2 < 2; s2++) begin
                    run_frame(8'hE5 ^ 8'(ln * 8 + pm * 3 + s2), ln, pm == 0, pm == 1, s2 != 0);
                    run_frame(8'hFA ^ 8'(ln * 19 + pm * 5), ln, pm == 0, pm == 1, s2 != 0);
                end

        // Back-to-back: 8 data bits, even parity, one stop bit (10 bits + 16).
        @(negedge clk);
        set_cfg(3, 0, 1, 0);
        tx_data = 8'h96; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        @(negedge clk);
        tx_data = 8'h2B; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        check("R9", "second char waits", buf_empty, 0);
        step(174);
        check("R9", "pending through stop", buf_empty, 0);
        check("R9", "stop of first char", txd, 1);
        step(1);
        check("R9", "buffer taken at stop end", buf_empty, 1);
        decode(8'h2B, 3, 0, 1, 0);

        // Reset in mid-frame with a character pending.
        @(negedge clk);
        set_cfg(1, 1, 0, 1);
        tx_data = 8'h55; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        @(negedge clk);
        tx_data = 8'hAA; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        step(20);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid-frame reset txd", txd, 1);
        check("R1", "mid-frame reset buf_empty", buf_empty, 1);
        check("R1", "mid-frame reset sr_empty", sr_empty, 1);
        rst_n = 1'b1;
        step(200);
        check("R1", "pending char discarded", sr_empty, 1);
        check("R10", "line stays high", txd, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule